// File: doc/BRIEF.md
# Receive Equalizer Freeze Sequencer

This sequencer pins the adaptive settings of a serial receiver's equalizer so that the recovered clock phase comes back the same after every restart. On the first startup it leaves all four equalizer loops free to adapt, resets the transceiver and waits a programmable settling time. It then reads each adapted value through a monitor port and writes it back through a register write port. Last, it asserts the override enables and resets the transceiver a second time. The four loops are gain control, high-frequency gain, low-frequency gain and offset cancellation.

On every later startup it skips adaptation and the monitor reads. It rewrites the stored values, keeps the overrides asserted and issues one reset. A recalibrate request reruns the full capture, for example between running periods. If reset-done does not come back within a fixed limit, the sequence stops with an error.

Top module: `eq_freeze_seq`

## Requirements
- R1: After reset, `xcvr_rst`, `cfg_req`, `busy`, `done` and `err` are low and `ovr_en` is all zero.
- R2: On a first startup, `xcvr_rst` pulses while `ovr_en` is all zero. Monitor reads start only after `xcvr_rst_done` is seen high and the design has then waited `dwell`+1 cycles. The first write request is raised `LAT+dwell+10` cycles after the accepted start, where `LAT` is the reset-done latency and each parameter read takes two cycles.
- R3: A monitor value is kept only when two back-to-back samples of `mon_data` are equal. On a mismatch both samples are taken again, so a word that changes during a read is never stored.
- R4: Write-back sends one transaction per parameter, with `cfg_sel` running 0, 1, 2, 3 (0 gain control, 1 high-frequency gain, 2 low-frequency gain, 3 offset). A transaction completes on a cycle with `cfg_req` and `cfg_rdy` both high. `cfg_sel` and `cfg_wdata` hold steady while `cfg_rdy` is low, and the data is the value captured for that parameter.
- R5: In the cycle after the last write is accepted, `ovr_en` is all ones and the second `xcvr_rst` pulse is issued. `done` rises once `xcvr_rst_done` is seen.
- R6: A later `start` raises `cfg_req` in the cycle right after the start is accepted. It performs no monitor read and no dwell, rewrites the stored values, keeps `ovr_en` all ones and issues exactly one reset pulse.
- R7: A `recal` pulse clears `ovr_en` and runs the full capture again, storing fresh monitor values.
- R8: If `xcvr_rst_done` stays low for `TMO` cycles after a reset, `err` goes high and `busy` goes low. A capture that ends in error is not treated as stored, so the next `start` runs a full capture.
- R9: `busy` is high from the accepted start until `done` or `err`. A `start` or `recal` that arrives while `busy` is high is dropped.
- R10: `xcvr_rst` is high for a single cycle per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a startup sequence |
| recal | input | 1 | Begin a full recapture |
| dwell | input | DW | Settling cycles after reset-done before reading |
| xcvr_rst | output | 1 | Transceiver reset pulse |
| xcvr_rst_done | input | 1 | Transceiver reset completed |
| mon_sel | output | IW | Parameter selected on the monitor port |
| mon_data | input | PW | Monitored value of the selected parameter |
| cfg_req | output | 1 | Register write request |
| cfg_sel | output | IW | Parameter being written |
| cfg_wdata | output | PW | Value being written |
| cfg_rdy | input | 1 | Write accepted this cycle |
| ovr_en | output | NPAR | Override enable, one bit per parameter |
| busy | output | 1 | Sequence running |
| done | output | 1 | Last sequence completed |
| err | output | 1 | Last sequence timed out |

## Verification
A start or recalibrate request can land in the same cycle as a write handshake that is still in progress. The bench raises `start` while a stalled write-back is under way. It then requires exactly four ordered writes and two reset pulses, and requires `done` to stay high with `busy` low afterwards. A second overlap comes from the monitor value changing on the very cycles the sequencer samples it. The bench toggles one parameter's monitor word on alternate cycles. It judges the result by the stored value that is written back and by the exact cycle of the first write request.

// File: rtl/eq_freeze_seq.sv
module eq_freeze_seq #(
  parameter int NPAR = 4,
  parameter int PW   = 8,
  parameter int DW   = 8,
  parameter int TMO  = 64,
  localparam int IW  = $clog2(NPAR),
  localparam int TW  = $clog2(TMO),
  localparam int CW  = (TW > DW) ? TW : DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            recal,
  input  logic [DW-1:0]   dwell,
  output logic            xcvr_rst,
  input  logic            xcvr_rst_done,
  output logic [IW-1:0]   mon_sel,
  input  logic [PW-1:0]   mon_data,
  output logic            cfg_req,
  output logic [IW-1:0]   cfg_sel,
  output logic [PW-1:0]   cfg_wdata,
  input  logic            cfg_rdy,
  output logic [NPAR-1:0] ovr_en,
  output logic            busy,
  output logic            done,
  output logic            err
);
  typedef enum logic [3:0] {
    S_IDLE, S_RST1, S_WAIT1, S_DWELL, S_RDA, S_RDB,
    S_WR, S_RST2, S_WAIT2, S_DONE, S_ERR
  } st_t;

  st_t           st;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [PW-1:0] samp;
  logic [PW-1:0] cap [NPAR];
  logic          captured;
  logic          ovr;

  wire go   = (start | recal) & ~busy;
  wire last = (idx == IW'(NPAR-1));
  wire tmo  = (cnt == CW'(TMO-1));

  assign busy      = !(st == S_IDLE || st == S_DONE || st == S_ERR);
  assign done      = (st == S_DONE);
  assign err       = (st == S_ERR);
  assign xcvr_rst  = (st == S_RST1) || (st == S_RST2);
  assign cfg_req   = (st == S_WR);
  assign mon_sel   = idx;
  assign cfg_sel   = idx;
  assign cfg_wdata = cap[idx];
  assign ovr_en    = {NPAR{ovr}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      cnt      <= '0;
      samp     <= '0;
      captured <= 1'b0;
      ovr      <= 1'b0;
      for (int i = 0; i < NPAR; i++) cap[i] <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_ERR: if (go) begin
          idx <= '0;
          cnt <= '0;
          if (recal || !captured) begin
            captured <= 1'b0;
            ovr      <= 1'b0;
            st       <= S_RST1;
          end else begin
            st <= S_WR;
          end
        end
        S_RST1: begin cnt <= '0; st <= S_WAIT1; end
        S_WAIT1:
          if (xcvr_rst_done) begin cnt <= '0; st <= S_DWELL; end
          else if (tmo)      st  <= S_ERR;
          else               cnt <= cnt + 1'b1;
        S_DWELL:
          if (cnt == CW'(dwell)) st <= S_RDA;
          else                   cnt <= cnt + 1'b1;
        S_RDA: begin samp <= mon_data; st <= S_RDB; end
        S_RDB:
          if (mon_data == samp) begin
            cap[idx] <= mon_data;
            if (last) begin idx <= '0; st <= S_WR; end
            else      begin idx <= idx + 1'b1; st <= S_RDA; end
          end else begin
            st <= S_RDA;
          end
        S_WR: if (cfg_rdy) begin
          if (last) begin idx <= '0; ovr <= 1'b1; st <= S_RST2; end
          else      idx <= idx + 1'b1;
        end
        S_RST2: begin cnt <= '0; st <= S_WAIT2; end
        S_WAIT2:
          if (xcvr_rst_done) begin captured <= 1'b1; st <= S_DONE; end
          else if (tmo)      st  <= S_ERR;
          else               cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eq_freeze_seq_chk.sv
module eq_freeze_seq_chk #(
  parameter int NPAR = 4,
  parameter int PW   = 8,
  localparam int IW  = $clog2(NPAR)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xcvr_rst,
  input logic            cfg_req,
  input logic [IW-1:0]   cfg_sel,
  input logic [PW-1:0]   cfg_wdata,
  input logic            cfg_rdy,
  input logic [NPAR-1:0] ovr_en,
  input logic            busy,
  input logic            done,
  input logic            err
);
  a_r10_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_rst |=> !xcvr_rst);

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_rdy) |=> (cfg_req && $stable(cfg_sel) && $stable(cfg_wdata)));

  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_rdy && cfg_sel != IW'(NPAR-1)) |=>
      (cfg_req && cfg_sel == IW'($past(cfg_sel) + 1'b1)));

  a_r5_ovr_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_rdy && cfg_sel == IW'(NPAR-1)) |=> (xcvr_rst && (&ovr_en)));

  a_r5_ovr_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en == '0) || (&ovr_en));

  a_r9_rst_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_rst || cfg_req) |-> busy);

  a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && (done || err)) && !(done && err));
endmodule

bind eq_freeze_seq eq_freeze_seq_chk #(.NPAR(NPAR), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xcvr_rst(xcvr_rst), .cfg_req(cfg_req),
  .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdy(cfg_rdy),
  .ovr_en(ovr_en), .busy(busy), .done(done), .err(err)
);

// File: tb/eq_freeze_seq_tb.sv
`timescale 1ns/1ps
module eq_freeze_seq_tb;
  logic       clk = 0, rst_n = 0, start = 0, recal = 0;
  logic [7:0] dwell = 0;
  logic       xcvr_rst, xcvr_rst_done = 0;
  logic [1:0] mon_sel, cfg_sel;
  logic [7:0] mon_data, cfg_wdata;
  logic       cfg_req, cfg_rdy = 0;
  logic [3:0] ovr_en;
  logic       busy, done, err;

  eq_freeze_seq u_dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int lat = 4, lc = 0, wmax = 0, wc = 0, nwr = 0, nrst = 0, bad_ovr = 0;
  bit lat_en = 1;
  logic [3:0] gcnt = 0, exp_ovr = 0;
  logic [7:0] mon_val [4];
  logic [7:0] old_val [4];
  logic [1:0] wr_sel [16];
  logic [7:0] wr_dat [16];
  logic [3:0] rst_log [8];

  assign mon_data = mon_val[mon_sel] ^ ((mon_sel == 2'd2 && gcnt[0]) ? 8'h5A : 8'h00);

  always @(negedge clk) begin
    if (xcvr_rst) begin
      if (nrst < 8) rst_log[nrst] = ovr_en;
      nrst++; xcvr_rst_done = 0; lc = lat;
    end else if (lat_en && lc > 0) begin
      if (lc == 1) xcvr_rst_done = 1;
      lc--;
    end
    if (mon_sel == 2'd2 && gcnt > 0) gcnt = gcnt - 1;
    if (cfg_req) begin
      if (wc >= wmax) begin
        cfg_rdy = 1;
        if (nwr < 16) begin wr_sel[nwr] = cfg_sel; wr_dat[nwr] = cfg_wdata; end
        if (ovr_en != exp_ovr) bad_ovr++;
        nwr++; wc = 0;
      end else begin cfg_rdy = 0; wc++; end
    end else begin cfg_rdy = 0; wc = 0; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic clr(input logic [3:0] eo);
    nwr = 0; nrst = 0; bad_ovr = 0; exp_ovr = eo;
  endtask

  task automatic launch(input bit s, input bit r, output int n);
    @(negedge clk); start = s; recal = r;
    @(posedge clk); #1; start = 0; recal = 0;
    n = 0;
    while (!cfg_req && !err && n < 500) begin @(posedge clk); #1; n++; end
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || err) && n < 2000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic chk_writes(input string tag, input bit use_old);
    chk(nwr == 4, {tag, " write count"}, nwr, 4);
    for (int k = 0; k < 4; k++) begin
      chk(wr_sel[k] == 2'(k), {tag, " write order"}, wr_sel[k], k);
      chk(wr_dat[k] == (use_old ? old_val[k] : mon_val[k]), {tag, " write data"},
          wr_dat[k], use_old ? old_val[k] : mon_val[k]);
    end
    chk(bad_ovr == 0, {tag, " ovr during writes"}, bad_ovr, 0);
  endtask

  initial begin
    int n;
    mon_val[0] = 8'h13; mon_val[1] = 8'hA7; mon_val[2] = 8'h3C; mon_val[3] = 8'hE1;
    repeat (3) @(posedge clk); #1;
    chk(!xcvr_rst && !cfg_req && !busy && !done && !err && ovr_en == 0,
        "R1 reset outputs", {xcvr_rst, cfg_req, busy, done, err}, 0);
    @(negedge clk); rst_n = 1;

    // first capture, glitched monitor on parameter 2
    lat = 4; dwell = 3; wmax = 1; gcnt = 4'd5; clr(4'h0);
    launch(1, 0, n);
    chk(n == 4 + 3 + 10 + 4, "R2 R3 first write latency", n, 21);
    chk(busy, "R9 busy while running", busy, 1);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    wait_end();
    chk(done && !err && !busy, "R5 done", {done, err, busy}, 4);
    chk_writes("R4 R3 capture", 0);
    chk(nrst == 2, "R9 reset count with ignored start", nrst, 2);
    chk(rst_log[0] == 4'h0, "R2 ovr low at first reset", rst_log[0], 0);
    chk(rst_log[1] == 4'hF, "R5 ovr high at second reset", rst_log[1], 15);
    repeat (5) @(posedge clk); #1;
    chk(done && !busy && nrst == 2, "R9 start while busy dropped", {done, busy}, 2);

    // replay: monitor changed, stored values must be used
    for (int k = 0; k < 4; k++) begin old_val[k] = mon_val[k]; mon_val[k] = mon_val[k] + 8'h21; end
    wmax = 0; clr(4'hF);
    launch(1, 0, n);
    chk(n == 0, "R6 replay write immediate", n, 0);
    wait_end();
    chk(done, "R6 replay done", done, 1);
    chk_writes("R6 replay", 1);
    chk(nrst == 1 && rst_log[0] == 4'hF, "R6 single reset with ovr", nrst, 1);
    chk(ovr_en == 4'hF, "R6 ovr kept", ovr_en, 15);

    // recalibrate
    lat = 3; dwell = 0; clr(4'h0);
    launch(0, 1, n);
    chk(n == 3 + 0 + 10, "R7 R2 recal latency", n, 13);
    wait_end();
    chk(done, "R7 recal done", done, 1);
    chk_writes("R7 recal", 0);
    chk(rst_log[0] == 4'h0 && rst_log[1] == 4'hF, "R7 ovr cleared then set",
        {rst_log[0], rst_log[1]}, 8'h0F);

    // timeout on replay
    lat_en = 0; clr(4'hF);
    launch(1, 0, n);
    wait_end();
    chk(err && !busy && !done, "R8 timeout error", {err, busy, done}, 4);

    // failed recapture then full capture on plain start
    clr(4'h0);
    launch(0, 1, n);
    wait_end();
    chk(err && nwr == 0, "R8 recal timeout", {err, nwr[3:0]}, 16);
    lat_en = 1; lat = 3; dwell = 2;
    for (int k = 0; k < 4; k++) mon_val[k] = 8'h80 + 8'(k * 7);
    clr(4'h0);
    launch(1, 0, n);
    chk(n == 3 + 2 + 10, "R8 full capture after failure", n, 15);
    wait_end();
    chk(done && !err, "R8 recovered done", {done, err}, 2);
    chk_writes("R8 recapture", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule